// File: doc/BRIEF.md
# Multiprocessor Interrupt Mask Router

This block routes device interrupt requests to four processors. Peripherals raise and drop request bits with side-band pulses on `irq_set` and `irq_clr`. The block keeps one shared 64-bit vector of pending requests. Each processor owns a 64-bit enable mask, and a 64-bit result register holds the requests that were routed to it. Each processor gets a level interrupt line that stays high while its result register is nonzero.

A separate real-time-clock flag is raised by a pulse on `rtc_event`. It drives its own line `rtc_irq` until software acknowledges it through the miscellaneous register.

Software uses a 64-bit register bus with a request handshake. `req_ready` is tied high, so the block never applies back-pressure: every cycle with `req_valid` high is one accepted request. Each accepted request, read or write, gets exactly one response on the next cycle, with `rsp_valid` high for that single cycle. The response has no ready input, so the requester must be able to take a response every cycle. The register index is `(req_addr & DEV_MASK) >> 6`, which places the registers on 64-byte strides.

Top module: `mp_irq_router`

## Requirements
- R1: When `rst_n` is low at a clock edge, the block clears the shared vector, every mask, every result register, the real-time-clock flag, all interrupt lines and `rsp_valid`.
- R2: The register index is `(req_addr & DEV_MASK) >> 6`, so address bits outside `DEV_MASK` are ignored. The index map is:
  - 0: status, which reads as zero.
  - 2: miscellaneous; the real-time-clock flag is bit 4.
  - 8+i: mask of processor i.
  - 12+i: result of processor i.
  - 16: shared vector.

  A read returns the register value as it stood in the request cycle.
- R3: Only `req_size` = 3 (a 64-bit access) is legal. Sizes 0, 1 and 2 (8, 16 and 32 bit) respond with `rsp_err` = 1 and `rsp_rdata` = 0, and change no state.
- R4: A set pulse ORs its bits into the shared vector. Every processor whose mask shares at least one bit with the pulse gets all of the pulse's bits ORed into its result register, and its line goes high.
- R5: A clear pulse removes its bits from the shared vector and from every result register. A processor's line is high exactly when its result register is nonzero, so the line stays high while other result bits remain.
- R6: A legal write to processor i's mask stores the new mask. If the new mask ANDed with the shared vector is nonzero, the result register takes that value and the line goes high. Otherwise the result register keeps its old value.
- R7: A bit that is both set and cleared in the same cycle ends cleared. In one cycle the block applies a mask write first, then set bits, then clear bits.
- R8: An `rtc_event` pulse sets the real-time-clock flag and `rtc_irq`. A legal miscellaneous write with bit 4 set clears them. A miscellaneous write without bit 4 responds with an error and changes nothing. An event and an acknowledge in the same cycle leave the flag set.
- R9: Writes to the status, result and shared-vector registers respond with an error and change no state.
- R10: Any index not listed in R2 reads as zero with an error, and a write to it responds with an error and has no effect.
- R11: `rsp_valid` is high in exactly the cycle after each accepted request. A write returns `rsp_rdata` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Bus request present |
| req_ready | output | 1 | Always 1: the block never applies back-pressure |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_size | input | 2 | Access size code: 0 = 8 bit, 1 = 16 bit, 2 = 32 bit, 3 = 64 bit |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Response strobe, one cycle after each accepted request |
| rsp_rdata | output | DATA_W | Read data |
| rsp_err | output | 1 | Access error for this response |
| irq_set | input | DATA_W | Pulse that sets request bits |
| irq_clr | input | DATA_W | Pulse that clears request bits |
| rtc_event | input | 1 | Real-time-clock tick |
| cpu_irq | output | NUM_CPU | Level interrupt line for each processor |
| rtc_irq | output | 1 | Real-time-clock interrupt line |

## Verification
The hardest situations to reach are the ones where several update paths hit the same result register in one cycle, or where the register ends up holding bits outside its own mask. The bench drives a mask write together with a set pulse in a single cycle, and a set and a clear of the same bit together. It also sets two bits at once where only one of them is enabled, then clears them one at a time, so the line must stay high on the bit that was never enabled. A sweep of every bit position through four overlapping masks, and of every register index, covers the fan-out and the decoder.

// File: rtl/mpir_pkg.sv
package mpir_pkg;
  localparam int unsigned STRIDE_SH       = 6;
  localparam int unsigned IDX_STATUS      = 0;
  localparam int unsigned IDX_MISC        = 2;
  localparam int unsigned IDX_MASK_BASE   = 8;
  localparam int unsigned IDX_RESULT_BASE = 12;
  localparam int unsigned IDX_RAW         = 16;
  localparam int unsigned MAX_CPU         = 4;
  localparam int unsigned RTC_BIT         = 4;
  localparam logic [1:0]  SIZE_FULL       = 2'd3;

  typedef enum logic [2:0] {
    RK_STATUS,
    RK_MISC,
    RK_MASK,
    RK_RESULT,
    RK_RAW,
    RK_NONE
  } reg_kind_e;
endpackage

// File: rtl/mpir_decode.sv
module mpir_decode
  import mpir_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter logic [ADDR_W-1:0] DEV_MASK = 'h7FF,
  parameter int unsigned NUM_CPU = 4,
  parameter int unsigned CPU_W = 2
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_kind_e         kind,
  output logic [CPU_W-1:0]  cpu_sel
);
  localparam logic [ADDR_W-1:0] MASK_LO = ADDR_W'(IDX_MASK_BASE);
  localparam logic [ADDR_W-1:0] MASK_HI = ADDR_W'(IDX_MASK_BASE + NUM_CPU);
  localparam logic [ADDR_W-1:0] RES_LO  = ADDR_W'(IDX_RESULT_BASE);
  localparam logic [ADDR_W-1:0] RES_HI  = ADDR_W'(IDX_RESULT_BASE + NUM_CPU);

  logic [ADDR_W-1:0] idx;
  assign idx = (addr & DEV_MASK) >> STRIDE_SH;

  always_comb begin
    kind    = RK_NONE;
    cpu_sel = '0;
    if (idx == ADDR_W'(IDX_STATUS)) begin
      kind = RK_STATUS;
    end else if (idx == ADDR_W'(IDX_MISC)) begin
      kind = RK_MISC;
    end else if (idx == ADDR_W'(IDX_RAW)) begin
      kind = RK_RAW;
    end else if (idx >= MASK_LO && idx < MASK_HI) begin
      kind    = RK_MASK;
      cpu_sel = CPU_W'(idx - MASK_LO);
    end else if (idx >= RES_LO && idx < RES_HI) begin
      kind    = RK_RESULT;
      cpu_sel = CPU_W'(idx - RES_LO);
    end
  end
endmodule

// File: rtl/mpir_cpu_slice.sv
module mpir_cpu_slice #(
  parameter int unsigned DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mask_we,
  input  logic [DATA_W-1:0] mask_wdata,
  input  logic [DATA_W-1:0] raw_q,
  input  logic [DATA_W-1:0] set_eff,
  input  logic [DATA_W-1:0] clr,
  output logic [DATA_W-1:0] mask_q,
  output logic [DATA_W-1:0] res_q,
  output logic              line_q
);
  logic [DATA_W-1:0] mask_d, res_d;
  logic              line_d;

  // ordering: mask write, then set, then clear
  always_comb begin
    mask_d = mask_we ? mask_wdata : mask_q;
    res_d  = res_q;
    line_d = line_q;
    if (mask_we && |(mask_wdata & raw_q)) begin
      res_d  = mask_wdata & raw_q;
      line_d = 1'b1;
    end
    if (|(set_eff & mask_d)) begin
      res_d  = res_d | set_eff;
      line_d = 1'b1;
    end
    if (|clr) begin
      res_d = res_d & ~clr;
      if (res_d == '0) line_d = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q <= '0;
      res_q  <= '0;
      line_q <= 1'b0;
    end else begin
      mask_q <= mask_d;
      res_q  <= res_d;
      line_q <= line_d;
    end
  end
endmodule

// File: rtl/mpir_rtc_flag.sv
module mpir_rtc_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic rtc_event,
  input  logic ack,
  output logic pending
);
  always_ff @(posedge clk) begin
    if (!rst_n)         pending <= 1'b0;
    else if (rtc_event) pending <= 1'b1;
    else if (ack)       pending <= 1'b0;
  end
endmodule

// File: rtl/mp_irq_router.sv
module mp_irq_router
  import mpir_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 64,
  parameter int unsigned NUM_CPU = 4,
  parameter logic [ADDR_W-1:0] DEV_MASK = 'h7FF
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_write,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [1:0]         req_size,
  input  logic [DATA_W-1:0]  req_wdata,
  output logic               rsp_valid,
  output logic [DATA_W-1:0]  rsp_rdata,
  output logic               rsp_err,
  input  logic [DATA_W-1:0]  irq_set,
  input  logic [DATA_W-1:0]  irq_clr,
  input  logic               rtc_event,
  output logic [NUM_CPU-1:0] cpu_irq,
  output logic               rtc_irq
);
  localparam int unsigned CPU_W = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1;

  reg_kind_e                     kind;
  logic [CPU_W-1:0]              cpu_sel;
  logic                          acc, full, err;
  logic                          mask_we_any, rtc_ack, rtc_q;
  logic [DATA_W-1:0]             rd_val, set_eff, raw_q;
  logic [NUM_CPU-1:0][DATA_W-1:0] mask_vec, res_vec;

  assign req_ready = 1'b1;
  assign acc       = req_valid && req_ready;
  assign full      = (req_size == SIZE_FULL);
  assign set_eff   = irq_set & ~irq_clr;

  mpir_decode #(
    .ADDR_W(ADDR_W), .DEV_MASK(DEV_MASK), .NUM_CPU(NUM_CPU), .CPU_W(CPU_W)
  ) u_dec (
    .addr(req_addr), .kind(kind), .cpu_sel(cpu_sel)
  );

  assign mask_we_any = acc && req_write && full && (kind == RK_MASK);
  assign rtc_ack     = acc && req_write && full && (kind == RK_MISC) && req_wdata[RTC_BIT];

  always_ff @(posedge clk) begin
    if (!rst_n) raw_q <= '0;
    else        raw_q <= (raw_q | set_eff) & ~irq_clr;
  end

  for (genvar g = 0; g < NUM_CPU; g++) begin : g_cpu
    mpir_cpu_slice #(.DATA_W(DATA_W)) u_slice (
      .clk       (clk),
      .rst_n     (rst_n),
      .mask_we   (mask_we_any && (cpu_sel == CPU_W'(g))),
      .mask_wdata(req_wdata),
      .raw_q     (raw_q),
      .set_eff   (set_eff),
      .clr       (irq_clr),
      .mask_q    (mask_vec[g]),
      .res_q     (res_vec[g]),
      .line_q    (cpu_irq[g])
    );
  end

  mpir_rtc_flag u_rtc (
    .clk(clk), .rst_n(rst_n), .rtc_event(rtc_event), .ack(rtc_ack), .pending(rtc_q)
  );
  assign rtc_irq = rtc_q;

  always_comb begin
    rd_val = '0;
    err    = 1'b0;
    if (!full) begin
      err = 1'b1;
    end else begin
      unique case (kind)
        RK_STATUS: err = req_write;
        RK_MISC: begin
          if (req_write) err = !req_wdata[RTC_BIT];
          else           rd_val[RTC_BIT] = rtc_q;
        end
        RK_MASK:   rd_val = mask_vec[cpu_sel];
        RK_RESULT: begin
          err    = req_write;
          rd_val = res_vec[cpu_sel];
        end
        RK_RAW: begin
          err    = req_write;
          rd_val = raw_q;
        end
        default:   err = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= acc;
      rsp_err   <= acc && err;
      rsp_rdata <= (acc && !req_write && !err) ? rd_val : '0;
    end
  end
endmodule

// File: rtl/mpir_checker.sv
module mpir_checker #(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned NUM_CPU = 4
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      req_valid,
  input logic [1:0]                req_size,
  input logic [DATA_W-1:0]         irq_set,
  input logic [DATA_W-1:0]         irq_clr,
  input logic                      rtc_event,
  input logic                      rsp_valid,
  input logic                      rsp_err,
  input logic [NUM_CPU-1:0]        cpu_irq,
  input logic                      rtc_irq,
  input logic [DATA_W-1:0]         raw_q,
  input logic [NUM_CPU-1:0][DATA_W-1:0] res_vec
);
  assert_rsp_follows_R11: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  assert_no_stray_rsp_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  assert_narrow_err_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_size != 2'd3) |=> rsp_err);
  assert_set_reaches_raw_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (|(irq_set & ~irq_clr)) |=>
      ((raw_q & $past(irq_set & ~irq_clr)) == $past(irq_set & ~irq_clr)));
  assert_clear_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (|irq_clr) |=> ((raw_q & $past(irq_clr)) == '0));
  assert_rtc_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rtc_event |=> rtc_irq);

  for (genvar g = 0; g < NUM_CPU; g++) begin : g_chk
    assert_line_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_irq[g] == (res_vec[g] != '0));
    assert_clear_result_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (|irq_clr) |=> ((res_vec[g] & $past(irq_clr)) == '0));
  end
endmodule

bind mp_irq_router mpir_checker #(.DATA_W(DATA_W), .NUM_CPU(NUM_CPU)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_size(req_size),
  .irq_set(irq_set), .irq_clr(irq_clr), .rtc_event(rtc_event),
  .rsp_valid(rsp_valid), .rsp_err(rsp_err), .cpu_irq(cpu_irq),
  .rtc_irq(rtc_irq), .raw_q(raw_q), .res_vec(res_vec)
);

// File: tb/mp_irq_router_tb.sv
module mp_irq_router_tb;
  localparam int CLK_P = 10;
  localparam logic [31:0] DMASK = 32'h7FF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, rtc_event = 1'b0;
  logic        req_ready, rsp_valid, rsp_err, rtc_irq;
  logic [31:0] req_addr = '0;
  logic [1:0]  req_size = 2'd3;
  logic [63:0] req_wdata = '0, irq_set = '0, irq_clr = '0, rsp_rdata;
  logic [3:0]  cpu_irq;

  int tests = 0, fails = 0;
  bit done = 1'b0;

  logic [63:0] m_raw = '0;
  logic [63:0] m_mask [4];
  logic [63:0] m_res [4];
  bit          m_rtc = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  mp_irq_router u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_size(req_size),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .rsp_err(rsp_err), .irq_set(irq_set), .irq_clr(irq_clr),
    .rtc_event(rtc_event), .cpu_irq(cpu_irq), .rtc_irq(rtc_irq)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [4:0] idx_of(input logic [31:0] a);
    return 5'(((a & DMASK) >> 6));
  endfunction

  function automatic void exp_rsp(input bit w, input logic [31:0] a, input logic [1:0] sz,
                                  input logic [63:0] wd, output logic [63:0] rd, output bit er);
    int ix;
    ix = int'(idx_of(a));
    rd = '0; er = 1'b0;
    if (sz != 2'd3) er = 1'b1;
    else if (ix == 0) er = w;
    else if (ix == 2) begin if (w) er = !wd[4]; else rd = 64'(m_rtc) << 4; end
    else if (ix >= 8 && ix < 12) rd = m_mask[ix-8];
    else if (ix >= 12 && ix < 16) begin er = w; rd = m_res[ix-12]; end
    else if (ix == 16) begin er = w; rd = m_raw; end
    else er = 1'b1;
    if (er || w) rd = '0;
  endfunction

  function automatic void model(input bit v, input bit w, input logic [31:0] a, input logic [1:0] sz,
                                input logic [63:0] wd, input logic [63:0] s, input logic [63:0] c,
                                input bit rtc);
    int ix;
    logic [63:0] es;
    bit ack;
    ix = int'(idx_of(a));
    ack = 1'b0;
    if (v && w && sz == 2'd3) begin
      if (ix >= 8 && ix < 12) begin
        m_mask[ix-8] = wd;
        if ((wd & m_raw) != 0) m_res[ix-8] = wd & m_raw;
      end
      if (ix == 2 && wd[4]) ack = 1'b1;
    end
    es = s & ~c;
    for (int i = 0; i < 4; i++) begin
      if ((es & m_mask[i]) != 0) m_res[i] = m_res[i] | es;
      m_res[i] = m_res[i] & ~c;
    end
    m_raw = (m_raw | es) & ~c;
    if (rtc) m_rtc = 1'b1;
    else if (ack) m_rtc = 1'b0;
  endfunction

  // one cycle: drive at negedge, capture at next negedge
  task automatic op(input string tag, input bit v, input bit w, input logic [31:0] a,
                    input logic [1:0] sz, input logic [63:0] wd, input logic [63:0] s,
                    input logic [63:0] c, input bit rtc);
    logic [63:0] erd;
    bit eer;
    logic [3:0] lines;
    exp_rsp(w, a, sz, wd, erd, eer);
    req_valid = v; req_write = w; req_addr = a; req_size = sz; req_wdata = wd;
    irq_set = s; irq_clr = c; rtc_event = rtc;
    @(negedge clk);
    model(v, w, a, sz, wd, s, c, rtc);
    chk({tag, " R11 rsp_valid"}, 64'(rsp_valid), 64'(v));
    if (v) begin
      chk({tag, " rsp_err"}, 64'(rsp_err), 64'(eer));
      chk({tag, " rsp_rdata"}, rsp_rdata, erd);
    end
    for (int i = 0; i < 4; i++) lines[i] = (m_res[i] != 0);
    chk({tag, " R5 cpu_irq"}, 64'(cpu_irq), 64'(lines));
    chk({tag, " R8 rtc_irq"}, 64'(rtc_irq), 64'(m_rtc));
    req_valid = 1'b0; req_write = 1'b0; irq_set = '0; irq_clr = '0; rtc_event = 1'b0;
  endtask

  task automatic rd(input string tag, input int ix);
    op(tag, 1'b1, 1'b0, 32'(ix) << 6, 2'd3, '0, '0, '0, 1'b0);
  endtask

  task automatic wr(input string tag, input int ix, input logic [63:0] d);
    op(tag, 1'b1, 1'b1, 32'(ix) << 6, 2'd3, d, '0, '0, 1'b0);
  endtask

  task automatic pulse(input string tag, input logic [63:0] s, input logic [63:0] c);
    op(tag, 1'b0, 1'b0, '0, 2'd3, '0, s, c, 1'b0);
  endtask

  task automatic read_all(input string tag);
    for (int i = 0; i < 4; i++) begin
      rd({tag, " mask"}, 8 + i);
      rd({tag, " result"}, 12 + i);
    end
    rd({tag, " raw"}, 16);
    rd({tag, " misc"}, 2);
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) begin m_mask[i] = '0; m_res[i] = '0; end
    // R1: reset state, with a set pulse held during reset
    irq_set = '1; rtc_event = 1'b1;
    repeat (3) @(negedge clk);
    irq_set = '0; rtc_event = 1'b0;
    rst_n = 1'b1;
    chk("R1 cpu_irq after reset", 64'(cpu_irq), 0);
    chk("R1 rtc_irq after reset", 64'(rtc_irq), 0);
    chk("R1 rsp_valid after reset", 64'(rsp_valid), 0);
    chk("R11 req_ready", 64'(req_ready), 1);
    read_all("R1 reset");

    // R2 / R10: every index
    for (int ix = 0; ix < 32; ix++) rd("R2 R10 index sweep", ix);
    for (int ix = 0; ix < 32; ix++)
      if (!(ix == 2 || (ix >= 8 && ix < 12))) wr("R9 R10 write sweep", ix, 64'hFFFF_FFFF_FFFF_FFFF);
    read_all("R9 R10 after write sweep");

    // masks
    wr("R6 mask0", 8, 64'h0000_0000_0000_00FF);
    wr("R6 mask1", 9, 64'h0000_0000_0000_FF00);
    wr("R6 mask2", 10, 64'h8000_0000_0000_0001);
    wr("R6 mask3", 11, 64'h0);
    // R2: aliased address, upper bits outside the device mask
    op("R2 alias read mask1", 1'b1, 1'b0, 32'hFFFF_F800 | (32'd9 << 6), 2'd3, '0, '0, '0, 1'b0);

    // R4 / R5: walk every bit
    for (int b = 0; b < 64; b++) begin
      pulse("R4 set bit", 64'd1 << b, '0);
      rd("R4 raw after set", 16);
      pulse("R5 clear bit", '0, 64'd1 << b);
    end
    read_all("R5 after walk");

    // R4: a pulse spanning an enabled and a disabled bit
    pulse("R4 set two bits", 64'h0000_0000_0001_0001, '0);
    rd("R4 result0 takes both bits", 12);
    pulse("R5 clear enabled bit", '0, 64'h1);
    rd("R5 result0 keeps outside bit", 12);
    pulse("R5 clear last bit", '0, 64'h0000_0000_0001_0000);

    // R6: mask write against a pending request
    pulse("R6 pending bit", 64'd1 << 40, '0);
    wr("R6 mask3 overlap", 11, (64'd1 << 40) | (64'd1 << 41));
    rd("R6 result3", 15);
    wr("R6 mask3 no overlap", 11, 64'd1 << 50);
    rd("R6 result3 kept", 15);
    pulse("R5 clear 40", '0, 64'd1 << 40);

    // R7: same-cycle conflicts
    pulse("R7 set and clear same bit", 64'h4, 64'h4);
    rd("R7 raw", 16);
    op("R7 mask write with set", 1'b1, 1'b1, 32'd9 << 6, 2'd3, 64'h20, 64'h20, '0, 1'b0);
    rd("R7 result1", 13);
    op("R7 mask write with clear", 1'b1, 1'b1, 32'd8 << 6, 2'd3, 64'h20, '0, 64'h20, 1'b0);
    read_all("R7 state");

    // R3: narrow accesses
    for (int sz = 0; sz < 3; sz++) begin
      op("R3 narrow write mask0", 1'b1, 1'b1, 32'd8 << 6, 2'(sz), 64'hDEAD, '0, '0, 1'b0);
      op("R3 narrow read raw", 1'b1, 1'b0, 32'd16 << 6, 2'(sz), '0, '0, '0, 1'b0);
      op("R3 narrow misc ack", 1'b1, 1'b1, 32'd2 << 6, 2'(sz), 64'h10, '0, '0, 1'b0);
    end
    read_all("R3 state unchanged");

    // R9: writes to read-only registers with pending state
    pulse("R9 pending", 64'h1, '0);
    wr("R9 write raw", 16, '0);
    wr("R9 write result0", 12, '0);
    wr("R9 write status", 0, '1);
    read_all("R9 state");

    // R8: real-time-clock flag
    op("R8 event", 1'b0, 1'b0, '0, 2'd3, '0, '0, '0, 1'b1);
    rd("R8 misc set", 2);
    wr("R8 misc write without bit4", 2, 64'hFFFF_FFFF_FFFF_FFEF);
    rd("R8 misc still set", 2);
    wr("R8 ack", 2, 64'h10);
    rd("R8 misc cleared", 2);
    op("R8 event", 1'b0, 1'b0, '0, 2'd3, '0, '0, '0, 1'b1);
    op("R8 event with ack", 1'b1, 1'b1, 32'd2 << 6, 2'd3, 64'h10, '0, '0, 1'b1);
    rd("R8 set wins", 2);
    wr("R8 final ack", 2, 64'h10);
    pulse("R5 clear all", '0, '1);
    read_all("final");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule